// File: doc/BRIEF.md
# Parallel Signature Compression Register

This block holds a 64-bit signature for one checking channel and updates it from a memory-mapped write port. Every write carries a data word, one strobe per byte lane and a mode code. When the mode code is zero, the write plants a seed: the register takes the written word as it is. Any other mode code folds the written word into the running signature with one step of a maximal-length linear feedback shift register, built on the primitive polynomial x^64 + x^4 + x^3 + x + 1. The current signature always appears on the read port.

Writes may be 8, 16, 32 or 64 bits wide. Byte lanes whose strobe is low count as zero, so a narrow write is a full 64-bit word with zeros in the lanes that were not written. Two clear inputs zero the signature. One is the channel's software reset bit. The other is a clear pulse from an outside sector controller. Either clear wins over a write in the same cycle.

Top module: `psa_signature_reg`

## Requirements
- R1: While the asynchronous active-low reset is asserted, and in the first cycle after it is released, the read port shows all zeros.
- R2: A write with mode code 0 replaces the signature, from the next cycle on, with the padded write word, whatever the signature was before.
- R3: A write with mode code 1, 2 or 3 sets the signature, from the next cycle on, to step(S) XOR D. Here S is the old signature and D is the padded write word. step(S) shifts S left by one bit, with a zero entering bit 0, and XORs in 64'h1B when bit 63 of S was 1.
- R4: The padded write word keeps byte lane k (bits 8k+7..8k) of the write data when strobe bit k is 1, and is zero in that lane when strobe bit k is 0. This holds for 8, 16, 32 and 64-bit accesses.
- R5: A high software reset input zeros the signature on the next clock edge.
- R6: A high sector clear input zeros the signature on the next clock edge. A write presented in the same cycle as either clear has no effect.
- R7: In a cycle with no write and no clear, the signature keeps its value.
- R8: With the signature seeded to 1, 64 consecutive compress writes of zero data leave the signature at 64'h1B. This follows from the feedback taps of the polynomial.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the signature updates on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for this channel |
| wr_data | input | 64 | Write data word |
| wr_strb | input | 8 | Byte-lane strobes; bit k enables lane k |
| wr_mode | input | 2 | Channel mode code; 0 seeds, any other value compresses |
| sw_clr | input | 1 | Software reset bit of the channel |
| sect_clr | input | 1 | Synchronous clear from the sector controller |
| rd_data | output | 64 | Current signature |

## Verification
Each result is due on the rising edge that samples its inputs: a seed, a compression or a clear is visible on the read port one cycle after it is presented. Reset acts at once, and idle cycles leave the value unchanged. The bench drives one operation per cycle on the falling edge. Its reference model takes the same operation at the rising edge. It compares the read port at the next falling edge, half a cycle after the result is due, so every clock is checked in its own cycle. A separate check after 64 zero-data compressions confirms the value the feedback taps predict.

// File: rtl/psa_pkg.sv
package psa_pkg;

  localparam int unsigned SIG_W  = 64;
  localparam int unsigned LANE_W = 8;
  localparam int unsigned MODE_W = 2;

  localparam logic [MODE_W-1:0] MODE_SEED = '0;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_CLEAR = 2'd1,
    OP_SEED  = 2'd2,
    OP_FOLD  = 2'd3
  } psa_op_e;

  // one LFSR step of the signature: shift up, feed the top bit back into the taps
  function automatic logic [SIG_W-1:0] lfsr_step(input logic [SIG_W-1:0] cur,
                                                  input logic [SIG_W-1:0] taps);
    logic [SIG_W-1:0] nxt;
    nxt = {cur[SIG_W-2:0], 1'b0};
    if (cur[SIG_W-1]) nxt = nxt ^ taps;
    return nxt;
  endfunction

  // select the operation for a cycle; clears come first
  function automatic psa_op_e pick_op(input logic wr, input logic seed_mode,
                                      input logic clr_a, input logic clr_b);
    psa_op_e op;
    if (clr_a || clr_b)  op = OP_CLEAR;
    else if (!wr)        op = OP_HOLD;
    else if (seed_mode)  op = OP_SEED;
    else                 op = OP_FOLD;
    return op;
  endfunction

endpackage

// File: rtl/psa_lane_pad.sv
module psa_lane_pad #(
  parameter int unsigned W      = 64,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned NL    = W / LANE_W
) (
  input  logic [W-1:0]  din,
  input  logic [NL-1:0] strb,
  output logic [W-1:0]  dout
);

  for (genvar k = 0; k < NL; k++) begin : g_lane
    assign dout[k*LANE_W +: LANE_W] = strb[k] ? din[k*LANE_W +: LANE_W] : '0;
  end

endmodule

// File: rtl/psa_misr_step.sv
module psa_misr_step #(
  parameter int unsigned  W    = 64,
  parameter logic [W-1:0] TAPS = 64'h1B
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] din,
  output logic [W-1:0] nxt
);

  logic fb;
  assign fb = cur[W-1];

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign nxt[i] = (TAPS[i] & fb) ^ din[i];
    end else begin : g_up
      assign nxt[i] = cur[i-1] ^ (TAPS[i] & fb) ^ din[i];
    end
  end

endmodule

// File: rtl/psa_sig_core.sv
module psa_sig_core
  import psa_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  psa_op_e      op,
  input  logic [W-1:0] seed_val,
  input  logic [W-1:0] fold_val,
  output logic [W-1:0] sig_q
);

  logic [W-1:0] sig_d;

  always_comb begin
    sig_d = sig_q;
    unique case (op)
      OP_CLEAR: sig_d = '0;
      OP_SEED:  sig_d = seed_val;
      OP_FOLD:  sig_d = fold_val;
      default:  sig_d = sig_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sig_q <= '0;
    else        sig_q <= sig_d;
  end

endmodule

// File: rtl/psa_signature_reg.sv
module psa_signature_reg
  import psa_pkg::*;
#(
  parameter int unsigned   W      = SIG_W,
  parameter int unsigned   LW     = LANE_W,
  parameter int unsigned   MW     = MODE_W,
  parameter logic [W-1:0]  TAPS   = 64'h1B,
  localparam int unsigned  NL     = W / LW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic [NL-1:0] wr_strb,
  input  logic [MW-1:0] wr_mode,
  input  logic          sw_clr,
  input  logic          sect_clr,
  output logic [W-1:0]  rd_data
);

  // named internal events for the checker
  logic [W-1:0] pad_data;
  logic [W-1:0] fold_data;
  logic [W-1:0] sig_q;
  psa_op_e      op;
  logic         seed_mode;
  logic         ev_clear;
  logic         ev_seed;
  logic         ev_fold;

  assign seed_mode = (wr_mode == MW'(0));
  assign op        = pick_op(wr_en, seed_mode, sw_clr, sect_clr);
  assign ev_clear  = (op == OP_CLEAR);
  assign ev_seed   = (op == OP_SEED);
  assign ev_fold   = (op == OP_FOLD);

  psa_lane_pad #(.W(W), .LANE_W(LW)) u_pad (
    .din  (wr_data),
    .strb (wr_strb),
    .dout (pad_data)
  );

  psa_misr_step #(.W(W), .TAPS(TAPS)) u_step (
    .cur (sig_q),
    .din (pad_data),
    .nxt (fold_data)
  );

  psa_sig_core #(.W(W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .seed_val (pad_data),
    .fold_val (fold_data),
    .sig_q    (sig_q)
  );

  assign rd_data = sig_q;

endmodule

// File: rtl/psa_sig_checker.sv
module psa_sig_checker #(
  parameter int unsigned  W    = 64,
  parameter int unsigned  LW   = 8,
  parameter logic [W-1:0] TAPS = 64'h1B,
  localparam int unsigned NL   = W / LW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [W-1:0]  wr_data,
  input logic [NL-1:0] wr_strb,
  input logic          sw_clr,
  input logic          sect_clr,
  input logic [W-1:0]  rd_data,
  input logic [W-1:0]  pad_data,
  input logic          ev_seed,
  input logic          ev_fold
);

  // bit mask of strobed lanes
  function automatic logic [W-1:0] lane_mask(input logic [NL-1:0] s);
    logic [W-1:0] m;
    for (int k = 0; k < NL; k++) m[k*LW +: LW] = {LW{s[k]}};
    return m;
  endfunction

  // step written as a conditional XOR of the shifted word
  function automatic logic [W-1:0] ref_step(input logic [W-1:0] s);
    return (s << 1) ^ ({W{s[W-1]}} & TAPS);
  endfunction

  assert_reset_zero_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> rd_data == '0);

  assert_seed_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_seed |=> rd_data == $past(pad_data));

  assert_fold_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fold |=> rd_data == (ref_step($past(rd_data)) ^ $past(pad_data)));

  assert_pad_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((pad_data & ~lane_mask(wr_strb)) == '0) &&
              ((pad_data & lane_mask(wr_strb)) == (wr_data & lane_mask(wr_strb))));

  assert_sw_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clr |=> rd_data == '0);

  assert_sector_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sect_clr |=> rd_data == '0);

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !sw_clr && !sect_clr) |=> $stable(rd_data));

endmodule

bind psa_signature_reg psa_sig_checker #(.W(W), .LW(LW), .TAPS(TAPS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr_en    (wr_en),
  .wr_data  (wr_data),
  .wr_strb  (wr_strb),
  .sw_clr   (sw_clr),
  .sect_clr (sect_clr),
  .rd_data  (rd_data),
  .pad_data (pad_data),
  .ev_seed  (ev_seed),
  .ev_fold  (ev_fold)
);

// File: tb/test_psa_signature_reg.sv
module test_psa_signature_reg;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic [7:0]  wr_strb = '0;
  logic [1:0]  wr_mode = '0;
  logic        sw_clr = 1'b0;
  logic        sect_clr = 1'b0;
  logic [63:0] rd_data;

  int checks = 0;
  int fails  = 0;
  logic [63:0] model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psa_signature_reg i_psa_signature_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_strb(wr_strb), .wr_mode(wr_mode), .sw_clr(sw_clr),
    .sect_clr(sect_clr), .rd_data(rd_data)
  );

  function automatic logic [63:0] padded(input logic [63:0] d, input logic [7:0] s);
    logic [63:0] r = '0;
    for (int b = 0; b < 64; b++) if (s[b/8]) r[b] = d[b];
    return r;
  endfunction

  function automatic logic [63:0] advance(input logic [63:0] v);
    logic top = v[63];
    v = v << 1;
    if (top) v = v ^ 64'h1B;
    return v;
  endfunction

  task automatic check(input string req, input logic [63:0] exp);
    checks++;
    if (rd_data !== exp) begin
      fails++;
      $display("FAIL %s: rd_data=%h expected=%h", req, rd_data, exp);
    end
  endtask

  // one operation per clock: drive at the falling edge, model at the rising
  // edge, compare at the next falling edge
  task automatic op(input string req, input logic en, input logic [1:0] md,
                    input logic [63:0] d, input logic [7:0] s,
                    input logic swc, input logic sc);
    wr_en = en; wr_mode = md; wr_data = d; wr_strb = s;
    sw_clr = swc; sect_clr = sc;
    @(posedge clk);
    if (swc || sc)        model = '0;
    else if (en && md==0) model = padded(d, s);
    else if (en)          model = advance(model) ^ padded(d, s);
    @(negedge clk);
    check(req, model);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    @(negedge clk);
    check("R1", 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 64'h0);

    op("R2", 1, 0, 64'hDEAD_BEEF_0123_4567, 8'hFF, 0, 0);
    op("R3", 1, 1, 64'h1111_2222_3333_4444, 8'hFF, 0, 0);
    op("R3", 1, 2, 64'h8000_0000_0000_0001, 8'hFF, 0, 0);
    op("R3", 1, 3, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 0, 0);
    op("R7", 0, 1, 64'hAAAA_AAAA_AAAA_AAAA, 8'hFF, 0, 0);
    op("R4", 1, 1, 64'hA5A5_A5A5_5A5A_5A5A, 8'h0F, 0, 0);
    op("R4", 1, 1, 64'hCAFE_F00D_1234_5678, 8'h30, 0, 0);
    op("R4", 1, 1, 64'h0102_0304_0506_0708, 8'h80, 0, 0);
    op("R4", 1, 2, 64'h0102_0304_0506_0708, 8'h00, 0, 0);
    op("R2", 1, 0, 64'h7777_6666_5555_4444, 8'h03, 0, 0);
    check("R2", 64'h0000_0000_0000_4444);
    op("R5", 0, 1, 64'h0, 8'h00, 1, 0);
    check("R5", 64'h0);
    op("R2", 1, 0, 64'h1234_5678_9ABC_DEF0, 8'hFF, 0, 0);
    op("R6", 1, 1, 64'hFFFF_0000_FFFF_0000, 8'hFF, 0, 1);
    check("R6", 64'h0);
    op("R2", 1, 0, 64'h0F0F_0F0F_0F0F_0F0F, 8'hFF, 0, 0);
    op("R6", 1, 0, 64'h1234_0000_0000_0000, 8'hFF, 1, 0);
    check("R6", 64'h0);
    op("R2", 1, 0, 64'h0000_0000_0000_0001, 8'h01, 0, 0);
    for (int n = 0; n < 64; n++) op("R8", 1, 1, 64'h0, 8'hFF, 0, 0);
    check("R8", 64'h0000_0000_0000_001B);
    for (int n = 0; n < 8; n++)
      op("R3", 1, 2'(1 + n % 3), {8{8'(n * 37 + 5)}}, 8'(1 << n), 0, 0);
    op("R7", 0, 0, 64'h0, 8'h00, 0, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule